// File: doc/BRIEF.md
# SDRAM Cross-Bank Burst Interrupt Scheduler

This block sits on the controller side of a multi-bank SDRAM and turns a stream of READ and WRITE requests into commands, letting a new burst to another bank cut short the burst in flight. For every command it works out four things. It decides when the data-mask line must lead a write so that read data coming off the device never overlaps write data from the controller. It decides which beats of the cut-off burst are still delivered. It decides when the controller drives the data bus. It decides when the bank whose burst was cut off, or whose burst ran to its end, begins its auto precharge.

Requests arrive on a valid/ready interface with a bank number, a write flag and an auto-precharge flag. A granted request appears as a command in the same cycle. Requests that would break a timing rule are held: a write that needs a mask lead waits one or two cycles, and a request to a bank that is precharging, or to a bank with a running auto-precharge burst, waits until the bank is free. CAS latency (2 or 3) and write recovery (1 to 3 clocks) are static configuration inputs. The precharge duration and the burst length are parameters.

Top module: `sdram_intr_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, cmd_valid, dqm, dq_oe and rd_valid are low and every pre_busy bit is clear.
- R2: A request to a free bank with no read data in flight is granted in the cycle it is presented. In that cycle cmd_valid is high and cmd_bank, cmd_write and cmd_ap repeat the request. A lone READ issued in cycle t gives rd_valid in cycles t+CL through t+CL+BURST_LEN-1. A lone WRITE issued in cycle t gives dq_oe in cycles t through t+BURST_LEN-1.
- R3: A READ issued in cycle t2 that interrupts a READ leaves rd_valid high without a gap. The new burst's beats occupy cycles t2+CL through t2+CL+BURST_LEN-1.
- R4: A WRITE that interrupts a READ without auto precharge is issued only after dqm has been high for exactly the one cycle before it. rd_valid is low from the write's cycle onward.
- R5: A WRITE that interrupts a READ with auto precharge is issued only after dqm has been high for the two cycles before it. rd_valid is low from the cycle before the write onward.
- R6: A READ issued in cycle tr that interrupts a WRITE ends dq_oe after cycle tr-1. The read data occupies cycles tr+CL through tr+CL+BURST_LEN-1.
- R7: A burst with auto precharge ends in cycle E. E is either the cycle an interrupting command is issued or the cycle after its last beat. For a READ, pre_busy of that bank is high for exactly PRE_CYC cycles, from E+1 to E+PRE_CYC.
- R8: For a WRITE with auto precharge ending in cycle E as defined in R7, pre_busy of that bank is high from E+1 to E+tWR+PRE_CYC, where tWR is cfg_wr_rec.
- R9: No command is issued to a bank while its pre_busy bit is set, nor to the bank of a running auto-precharge burst. Such a request is held and granted on the first cycle the bank is free.
- R10: rd_valid and dq_oe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = WRITE, 0 = READ |
| req_bank | input | BANK_W | Target bank |
| req_ap | input | 1 | Auto precharge after this burst |
| cfg_cas_lat | input | 2 | CAS latency, 2 or 3 (any other value acts as 2) |
| cfg_wr_rec | input | 2 | Write recovery in clocks, 1 to 3 (0 acts as 1) |
| req_ready | output | 1 | Request can be granted this cycle |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_write | output | 1 | Issued command is a WRITE |
| cmd_bank | output | BANK_W | Bank of issued command |
| cmd_ap | output | 1 | Issued command carries auto precharge |
| dqm | output | 1 | Data mask toward the device |
| dq_oe | output | 1 | Controller drives write data this cycle |
| rd_valid | output | 1 | Device delivers an unmasked read beat this cycle |
| pre_busy | output | NUM_BANKS | Per-bank precharge or recovery in progress |

## Verification
Commands are due in the same cycle the request is presented. dq_oe follows the write command with no delay. rd_valid follows the read command after exactly CL cycles. Masking takes effect one cycle after dqm rises. pre_busy rises one cycle after the burst's end cycle. Every scenario drives its requests just after a falling edge and samples 2 ns later, before the next rising edge. Each output is recorded into a 16-cycle bit vector indexed from the first request. These vectors, together with the grant cycles, are compared with windows computed from the timing rules in the requirements, for both CAS latencies and for write recovery times of 1 and 3.

// File: rtl/sdram_intr_pkg.sv
package sdram_intr_pkg;
  localparam int CL_MAX = 3;
  localparam int LEAD_W = 2;

  typedef struct packed {
    logic live;
    logic write;
    logic ap;
  } burst_t;

  function automatic logic [LEAD_W-1:0] lead_needed(input logic ap);
    return ap ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/sdram_intr_burst.sv
module sdram_intr_burst
  import sdram_intr_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int BANK_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  input  logic              g_write,
  input  logic [BANK_W-1:0] g_bank,
  input  logic              g_ap,
  output logic              rd_src,
  output logic              rd_pending,
  output logic              dq_oe,
  output logic              end_evt,
  output logic [BANK_W-1:0] end_bank,
  output logic              end_wr,
  output logic              end_ap,
  output logic              cur_live,
  output logic              cur_ap
);
  localparam int CNT_W = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;

  burst_t            cur_q, cur_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              beat_more;

  assign beat_more  = cur_q.live && (cnt_q != '0);
  assign end_evt    = cur_q.live && ((cnt_q == '0) || grant);
  assign end_bank   = bank_q;
  assign end_wr     = cur_q.write;
  assign end_ap     = cur_q.ap;
  assign cur_live   = cur_q.live;
  assign cur_ap     = cur_q.ap;
  assign rd_pending = beat_more && !cur_q.write;
  assign rd_src     = (grant && !g_write) || (beat_more && !cur_q.write && !grant);
  assign dq_oe      = (grant && g_write) || (beat_more && cur_q.write && !grant);

  always_comb begin
    cur_d  = cur_q;
    cnt_d  = cnt_q;
    bank_d = bank_q;
    if (grant) begin
      cur_d  = '{live: 1'b1, write: g_write, ap: g_ap};
      cnt_d  = CNT_W'(BURST_LEN - 1);
      bank_d = g_bank;
    end else if (end_evt) begin
      cur_d.live = 1'b0;
    end else if (beat_more) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      cnt_q  <= '0;
      bank_q <= '0;
    end else begin
      cur_q  <= cur_d;
      cnt_q  <= cnt_d;
      bank_q <= bank_d;
    end
  end

  // R6: once a READ is issued, the controller stops driving unless a new WRITE is issued
  a_r6_oe_stops_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !g_write) |=> (!dq_oe || (grant && g_write)));
endmodule

// File: rtl/sdram_intr_rdpath.sv
module sdram_intr_rdpath
  import sdram_intr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cl3,
  input  logic rd_src,
  input  logic rd_pending,
  input  logic rd_grant,
  input  logic rd_grant_ap,
  input  logic wr_grant,
  input  logic wr_wait,
  output logic rd_busy,
  output logic lead_ok,
  output logic dqm,
  output logic rd_valid
);
  logic [CL_MAX-1:0] sh_q, sh_d, win;
  logic [LEAD_W-1:0] lead_q, lead_d;
  logic              dqm_q, ap_q, ap_d;
  logic [1:0]        head_idx;

  for (genvar i = 0; i < CL_MAX; i++) begin : g_win
    assign win[i] = (i < 2) ? 1'b1 : cl3;
  end

  assign head_idx = cl3 ? 2'd2 : 2'd1;
  assign rd_busy  = rd_pending || ((sh_q & win) != '0);
  assign lead_ok  = !rd_busy || (lead_q >= lead_needed(ap_q));
  assign dqm      = wr_wait && !lead_ok;
  assign rd_valid = sh_q[head_idx] && !dqm_q;

  always_comb begin
    sh_d   = wr_grant ? '0 : {sh_q[CL_MAX-2:0], rd_src};
    lead_d = dqm ? ((lead_q == 2'd2) ? 2'd2 : lead_q + 2'd1) : 2'd0;
    ap_d   = rd_grant ? rd_grant_ap : ap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      lead_q <= '0;
      dqm_q  <= 1'b0;
      ap_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      lead_q <= lead_d;
      dqm_q  <= dqm;
      ap_q   <= ap_d;
    end
  end

  // R4: a write cutting into read traffic was preceded by a mask cycle
  a_r4_mask_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_grant && rd_busy) |-> $past(dqm));
  // R5: after an auto-precharge read the mask leads by two cycles
  a_r5_two_cycle_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_grant && rd_busy && ap_q) |-> ($past(dqm) && $past(dqm, 2)));
endmodule

// File: rtl/sdram_intr_bank_pre.sv
module sdram_intr_bank_pre #(
  parameter int PRE_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_rd,
  input  logic       start_wr,
  input  logic [1:0] wr_rec,
  output logic       busy
);
  localparam int BC_W = $clog2(PRE_CYC + 1);

  logic [1:0]      wait_q, wait_d;
  logic [BC_W-1:0] bcnt_q, bcnt_d;

  assign busy = (wait_q != '0) || (bcnt_q != '0);

  always_comb begin
    wait_d = wait_q;
    bcnt_d = bcnt_q;
    if (bcnt_q != '0) bcnt_d = bcnt_q - 1'b1;
    if (start_rd) begin
      bcnt_d = BC_W'(PRE_CYC);
    end else if (start_wr) begin
      wait_d = wr_rec;
    end else if (wait_q == 2'd1) begin
      wait_d = 2'd0;
      bcnt_d = BC_W'(PRE_CYC);
    end else if (wait_q != 2'd0) begin
      wait_d = wait_q - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      bcnt_q <= '0;
    end else begin
      wait_q <= wait_d;
      bcnt_q <= bcnt_d;
    end
  end

  // R9: a bank never starts a new precharge while one is still running
  a_r9_start_on_idle_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd || start_wr) |-> !busy);
endmodule

// File: rtl/sdram_intr_sched.sv
module sdram_intr_sched
  import sdram_intr_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int PRE_CYC   = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic                 req_ap,
  input  logic [1:0]           cfg_cas_lat,
  input  logic [1:0]           cfg_wr_rec,
  output logic                 req_ready,
  output logic                 cmd_valid,
  output logic                 cmd_write,
  output logic [BANK_W-1:0]    cmd_bank,
  output logic                 cmd_ap,
  output logic                 dqm,
  output logic                 dq_oe,
  output logic                 rd_valid,
  output logic [NUM_BANKS-1:0] pre_busy
);
  logic              cl3, bank_block, grant, wr_wait;
  logic [1:0]        wr_rec_eff;
  logic              rd_src, rd_pending, rd_busy, lead_ok;
  logic              end_evt, end_wr, end_ap, cur_live, cur_ap;
  logic [BANK_W-1:0] end_bank;

  assign cl3        = (cfg_cas_lat == 2'd3);
  assign wr_rec_eff = (cfg_wr_rec == 2'd0) ? 2'd1 : cfg_wr_rec;

  // the running burst's bank is end_bank until it ends
  assign bank_block = pre_busy[req_bank] || (cur_live && cur_ap && (end_bank == req_bank));
  assign req_ready  = !bank_block && (!req_write || lead_ok);
  assign grant      = req_valid && req_ready;
  assign wr_wait    = req_valid && req_write && !bank_block;

  assign cmd_valid = grant;
  assign cmd_write = grant && req_write;
  assign cmd_bank  = grant ? req_bank : '0;
  assign cmd_ap    = grant && req_ap;

  sdram_intr_burst #(.BURST_LEN(BURST_LEN), .BANK_W(BANK_W)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (grant),
    .g_write    (req_write),
    .g_bank     (req_bank),
    .g_ap       (req_ap),
    .rd_src     (rd_src),
    .rd_pending (rd_pending),
    .dq_oe      (dq_oe),
    .end_evt    (end_evt),
    .end_bank   (end_bank),
    .end_wr     (end_wr),
    .end_ap     (end_ap),
    .cur_live   (cur_live),
    .cur_ap     (cur_ap)
  );

  sdram_intr_rdpath u_rdpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .cl3         (cl3),
    .rd_src      (rd_src),
    .rd_pending  (rd_pending),
    .rd_grant    (grant && !req_write),
    .rd_grant_ap (req_ap),
    .wr_grant    (grant && req_write),
    .wr_wait     (wr_wait),
    .rd_busy     (rd_busy),
    .lead_ok     (lead_ok),
    .dqm         (dqm),
    .rd_valid    (rd_valid)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = end_evt && end_ap && (end_bank == BANK_W'(b));
    sdram_intr_bank_pre #(.PRE_CYC(PRE_CYC)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_rd (hit && !end_wr),
      .start_wr (hit && end_wr),
      .wr_rec   (wr_rec_eff),
      .busy     (pre_busy[b])
    );
  end

  // R10: controller and device never drive the data bus together
  a_r10_no_bus_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && dq_oe));
  // R9: no command reaches a bank that is precharging
  a_r9_no_cmd_to_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !pre_busy[cmd_bank]);
  // R2: commands only appear for presented requests
  a_r2_cmd_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> req_valid);
endmodule

// File: tb/sdram_intr_sched_tb.sv
module sdram_intr_sched_tb_top;
  localparam int NB = 4;
  localparam int NC = 16;

  logic          clk, rst_n;
  logic          req_valid, req_write, req_ap;
  logic [1:0]    req_bank, cfg_cas_lat, cfg_wr_rec;
  logic          req_ready, cmd_valid, cmd_write, cmd_ap, dqm, dq_oe, rd_valid;
  logic [1:0]    cmd_bank;
  logic [NB-1:0] pre_busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int         q_start [3];
  logic       q_wr    [3];
  logic [1:0] q_bank  [3];
  logic       q_ap    [3];
  int         g_cyc   [3];
  logic [1:0] g_bank  [3];
  logic       g_wr    [3];
  logic [NC-1:0] rec_rdv, rec_oe, rec_dqm;
  logic [NC-1:0] rec_pb [NB];

  sdram_intr_sched dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_ap(req_ap), .cfg_cas_lat(cfg_cas_lat),
    .cfg_wr_rec(cfg_wr_rec), .req_ready(req_ready), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .dqm(dqm),
    .dq_oe(dq_oe), .rd_valid(rd_valid), .pre_busy(pre_busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [NC-1:0] rng(input int lo, input int hi);
    logic [NC-1:0] m = '0;
    for (int i = lo; i <= hi; i++) if (i >= 0 && i < NC) m[i] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic set_req(input int i, input int st, input logic wr, input logic [1:0] bk, input logic ap);
    q_start[i] = st; q_wr[i] = wr; q_bank[i] = bk; q_ap[i] = ap; g_cyc[i] = -1;
  endtask

  task automatic run_seq(input int nreq);
    int idx = 0;
    for (int k = 0; k < NC; k++) begin
      @(negedge clk);
      if (idx < nreq && k >= q_start[idx]) begin
        req_valid = 1'b1; req_write = q_wr[idx]; req_bank = q_bank[idx]; req_ap = q_ap[idx];
      end else begin
        req_valid = 1'b0;
      end
      #2;
      rec_rdv[k] = rd_valid; rec_oe[k] = dq_oe; rec_dqm[k] = dqm;
      for (int b = 0; b < NB; b++) rec_pb[b][k] = pre_busy[b];
      if (req_valid && cmd_valid) begin
        g_cyc[idx] = k; g_bank[idx] = cmd_bank; g_wr[idx] = cmd_write; idx++;
      end
    end
    @(negedge clk); req_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk("R10 bus overlap", 32'(rec_rdv & rec_oe), 32'h0);
  endtask

  task automatic t_reset();
    #2;
    chk("R1 cmd_valid in reset", 32'(cmd_valid), 32'h0);
    chk("R1 pre_busy in reset", 32'(pre_busy), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R1 dqm/oe/rdv after reset", {29'h0, dqm, dq_oe, rd_valid}, 32'h0);
    chk("R1 cmd/pre_busy after reset", {27'h0, cmd_valid, pre_busy}, 32'h0);
  endtask

  task automatic t_single(input int cl);
    cfg_cas_lat = 2'(cl);
    set_req(0, 0, 1'b0, 2'd1, 1'b0);
    run_seq(1);
    chk("R2 read grant cycle", 32'(g_cyc[0]), 32'd0);
    chk("R2 read cmd bank", 32'(g_bank[0]), 32'd1);
    chk("R2 read cmd type", 32'(g_wr[0]), 32'd0);
    chk("R2 read data window", 32'(rec_rdv), 32'(rng(cl, cl + 3)));
    set_req(0, 0, 1'b1, 2'd2, 1'b0);
    run_seq(1);
    chk("R2 write cmd bank/type", {30'h0, g_wr[0], g_bank[0] == 2'd2}, 32'h3);
    chk("R2 write drive window", 32'(rec_oe), 32'(rng(0, 3)));
    chk("R2 write no mask no read", 32'(rec_dqm | rec_rdv), 32'h0);
  endtask

  task automatic t_rd_rd(input int cl);
    cfg_cas_lat = 2'(cl);
    set_req(0, 0, 1'b0, 2'd0, 1'b0);
    set_req(1, 2, 1'b0, 2'd1, 1'b0);
    run_seq(2);
    chk("R3 interrupt grant", 32'(g_cyc[1]), 32'd2);
    chk("R3 seamless read data", 32'(rec_rdv), 32'(rng(cl, cl + 5)));
  endtask

  task automatic t_wr_after_rd(input int cl, input logic ap);
    cfg_cas_lat = 2'(cl);
    set_req(0, 0, 1'b0, 2'd0, ap);
    set_req(1, 3, 1'b1, 2'd1, 1'b0);
    run_seq(2);
    if (!ap) begin
      chk("R4 write stalled one cycle", 32'(g_cyc[1]), 32'd4);
      chk("R4 mask lead", 32'(rec_dqm), 32'(rng(3, 3)));
      chk("R4 read beats kept", 32'(rec_rdv), 32'(rng(cl, 3)));
      chk("R4 write drive", 32'(rec_oe), 32'(rng(4, 7)));
    end else begin
      chk("R5 write stalled two cycles", 32'(g_cyc[1]), 32'd5);
      chk("R5 mask lead", 32'(rec_dqm), 32'(rng(3, 4)));
      chk("R5 read beats kept", 32'(rec_rdv), 32'(rng(cl, 3)));
      chk("R5 write drive", 32'(rec_oe), 32'(rng(5, 8)));
      chk("R7 natural-end read precharge", 32'(rec_pb[0]), 32'(rng(5, 7)));
    end
  endtask

  task automatic t_rd_after_wr(input int cl);
    cfg_cas_lat = 2'(cl);
    set_req(0, 0, 1'b1, 2'd0, 1'b0);
    set_req(1, 2, 1'b0, 2'd1, 1'b0);
    run_seq(2);
    chk("R6 read grant", 32'(g_cyc[1]), 32'd2);
    chk("R6 write cut", 32'(rec_oe), 32'(rng(0, 1)));
    chk("R6 read data", 32'(rec_rdv), 32'(rng(2 + cl, 5 + cl)));
  endtask

  task automatic t_rdap_intr();
    cfg_cas_lat = 2'd2;
    set_req(0, 0, 1'b0, 2'd0, 1'b1);
    set_req(1, 2, 1'b0, 2'd1, 1'b0);
    set_req(2, 3, 1'b0, 2'd0, 1'b0);
    run_seq(3);
    chk("R7 precharge from interrupt", 32'(rec_pb[0]), 32'(rng(3, 5)));
    chk("R7 other bank idle", 32'(rec_pb[1]), 32'h0);
    chk("R9 busy bank request held", 32'(g_cyc[2]), 32'd6);
  endtask

  task automatic t_wrap_intr(input int twr);
    cfg_wr_rec = 2'(twr);
    set_req(0, 0, 1'b1, 2'd0, 1'b1);
    set_req(1, 2, 1'b1, 2'd1, 1'b0);
    run_seq(2);
    chk("R8 recovery then precharge", 32'(rec_pb[0]), 32'(rng(3, 2 + twr + 3)));
    chk("R8 write drive continuous", 32'(rec_oe), 32'(rng(0, 5)));
  endtask

  task automatic t_same_bank_ap();
    cfg_cas_lat = 2'd2;
    set_req(0, 0, 1'b0, 2'd0, 1'b1);
    set_req(1, 1, 1'b0, 2'd0, 1'b0);
    run_seq(2);
    chk("R9 same bank as auto-precharge burst held", 32'(g_cyc[1]), 32'd8);
    chk("R9 natural-end precharge", 32'(rec_pb[0]), 32'(rng(5, 7)));
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_bank = '0; req_ap = 1'b0;
    cfg_cas_lat = 2'd2; cfg_wr_rec = 2'd2;
    repeat (3) @(negedge clk);
    t_reset();
    repeat (2) @(negedge clk);
    t_single(2);
    t_single(3);
    t_rd_rd(2);
    t_rd_rd(3);
    t_wr_after_rd(2, 1'b0);
    t_wr_after_rd(3, 1'b0);
    t_wr_after_rd(2, 1'b1);
    t_wr_after_rd(3, 1'b1);
    t_rd_after_wr(2);
    t_rd_after_wr(3);
    t_rdap_intr();
    t_wrap_intr(1);
    t_wrap_intr(3);
    t_same_bank_ap();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule